// File: doc/BRIEF.md
# Three-Pair Complementary PWM Generator with Dead-Time

This block drives three motor half-bridges. One shared up-counter sets the PWM period from a programmable modulus. Each of the three channel pairs compares that counter with its own duty value to form an ideal top waveform, and the bottom waveform is its complement. A dead-time stage on each output holds back every turn-on edge by a programmable number of clocks, so the two switches of a half-bridge are never driven on together.

Software programs the block through a single-cycle write port. Modulus and duty values first go to shadow registers and reach the live copies only when the counter wraps, so a period never mixes old and new settings. Dead-time and polarity writes take effect at once. Top outputs and bottom outputs each have their own polarity bit. A fault input turns all six outputs off in the same cycle. The shutdown then stays latched until the fault is gone, software has written a clear, and a period boundary has been reached.

Top module: `cpwm_top`

## Requirements
- R1: The counter runs from 0 to modulus-1 and wraps, so every output repeats with a period of exactly modulus clocks. This holds for a modulus of 2 or more, written at address 0.
- R2: The ideal top signal of pair k is high while the counter is below that pair's compare value (address 4+k). The ideal bottom signal is its complement. For a compare value C with 0 < C < modulus M and dead-time D (address 1), the top output is active for max(C-D,0) clocks per period. The bottom output is active for max(M-C-D,0) clocks per period.
- R3: Each turn-on of a top or bottom output is delayed by D clocks after its ideal signal rises. Turn-off is not delayed. The top and bottom outputs of a pair are never active in the same cycle.
- R4: An ideal pulse of D clocks or fewer produces no active output pulse at all.
- R5: A compare value of 0 keeps the top output inactive and the bottom output continuously active. A compare value at or above the modulus keeps the top output continuously active and the bottom output inactive. In both cases there is no glitch.
- R6: A write to the modulus or to a compare value takes effect only at the next counter wrap. A compare change written mid-period does not alter the current period.
- R7: A write to address 2 sets the polarity. Bit 0 makes the top outputs active-low, and bit 1 makes the bottom outputs active-low. Each pin equals its active state XOR its polarity bit, and the inactive level equals the polarity bit.
- R8: While fault_i is high, all six outputs sit at their inactive levels, starting in the same cycle fault_i rises.
- R9: After fault_i falls, the outputs stay inactive until a clear is written with fault_i low (address 3, bit 0 = 1). They then resume at the next counter wrap, starting with the top turn-on of the new period. A clear written while fault_i is high is discarded.
- R10: While rst_ni is low, all outputs are 0 and all registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register address: 0 modulus, 1 dead-time, 2 polarity, 3 fault clear, 4..6 compare of pairs 0..2 |
| wr_data_i | input | 12 | Register write data |
| fault_i | input | 1 | Fault shutdown request, synchronous to clk_i |
| pwm_top_o | output | 3 | Top outputs, one per pair |
| pwm_bot_o | output | 3 | Bottom outputs, one per pair |

## Verification
A register write lands one edge after it is driven. A modulus or duty change reaches the outputs only after the next wrap, plus one register stage, plus the dead-time. The bench therefore waits at least one old period plus several new periods before it measures. It then counts active cycles, turn-on edges and top/bottom overlaps over a window of exactly four periods, so the result does not depend on the counter phase. Fault gating is combinational and is sampled 1 ns after fault_i changes. The buffered-reload and fault-resume checks synchronise on an observed top turn-off, and they time the next write from a free-running cycle count, so the counter position at that write is known.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MOD  = 3'd0,
    A_DEAD = 3'd1,
    A_POL  = 3'd2,
    A_CLR  = 3'd3,
    A_CMP0 = 3'd4
  } cpwm_addr_e;

  typedef struct packed {
    logic bot_low;
    logic top_low;
  } cpwm_pol_t;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W     = 12,
  parameter int NUM_PAIRS = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [CNT_W-1:0]                    mod_shd_i,
  input  logic [NUM_PAIRS-1:0][CNT_W-1:0]     cmp_shd_i,
  output logic [CNT_W-1:0]                    cnt_o,
  output logic [NUM_PAIRS-1:0][CNT_W-1:0]     cmp_act_o,
  output logic                                wrap_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0]                cnt_q;
  logic [CNT_W-1:0]                mod_q;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] cmp_q;
  logic [EXT_W-1:0]                cnt_inc;
  logic                            wrap;

  assign cnt_inc = EXT_W'(cnt_q) + EXT_W'(1);
  assign wrap    = cnt_inc >= EXT_W'(mod_q);

  // live values reload only at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= '0;
      cmp_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      mod_q <= mod_shd_i;
      cmp_q <= cmp_shd_i;
    end else begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt_o     = cnt_q;
  assign cmp_act_o = cmp_q;
  assign wrap_o    = wrap;

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q == '0) || (cnt_q < mod_q));

  assert_cmp_held_mid_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(cmp_q));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_i,
  input  logic            ideal_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            act_o
);
  logic [DT_W-1:0] wait_q;
  logic            act_q;

  // turn-on waits dead_i clocks of steady ideal high; turn-off is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      act_q  <= 1'b0;
    end else if (halt_i || !ideal_i) begin
      wait_q <= '0;
      act_q  <= 1'b0;
    end else if (wait_q >= dead_i) begin
      act_q  <= 1'b1;
    end else begin
      wait_q <= wait_q + DT_W'(1);
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             top_act_o,
  output logic             bot_act_o
);
  logic ideal_top;
  logic ideal_bot;

  assign ideal_top = cnt_i < cmp_i;
  assign ideal_bot = !ideal_top;

  cpwm_deadband #(.DT_W(DT_W)) u_db_top (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (halt_i),
    .ideal_i(ideal_top),
    .dead_i (dead_i),
    .act_o  (top_act_o)
  );

  cpwm_deadband #(.DT_W(DT_W)) u_db_bot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (halt_i),
    .ideal_i(ideal_bot),
    .dead_i (dead_i),
    .act_o  (bot_act_o)
  );

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_act_o && bot_act_o));
endmodule

// File: rtl/cpwm_fault.sv
module cpwm_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic clr_i,
  input  logic wrap_i,
  output logic halt_o
);
  logic latched_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_q <= 1'b0;
      pend_q    <= 1'b0;
    end else if (fault_i) begin
      latched_q <= 1'b1;
      pend_q    <= 1'b0;   // clear written during fault is dropped
    end else if (wrap_i && pend_q) begin
      latched_q <= 1'b0;
      pend_q    <= 1'b0;
    end else if (clr_i && latched_q) begin
      pend_q    <= 1'b1;
    end
  end

  // fault_i gates combinationally for same-cycle shutdown
  assign halt_o = fault_i || latched_q;

  assert_fault_latches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> latched_q);

  assert_release_on_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> !$fell(latched_q));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DT_W      = 8,
  parameter int NUM_PAIRS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  input  logic                  fault_i,
  output logic [NUM_PAIRS-1:0]  pwm_top_o,
  output logic [NUM_PAIRS-1:0]  pwm_bot_o
);
  logic [CNT_W-1:0]                mod_shd_q;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] cmp_shd_q;
  logic [DT_W-1:0]                 dead_q;
  cpwm_pol_t                       pol_q;
  logic                            clr_wr;

  logic [CNT_W-1:0]                cnt;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] cmp_act;
  logic                            wrap;
  logic                            halt;
  logic [NUM_PAIRS-1:0]            top_act;
  logic [NUM_PAIRS-1:0]            bot_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_shd_q <= '0;
      dead_q    <= '0;
      pol_q     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MOD)  mod_shd_q <= wr_data_i;
      if (wr_addr_i == A_DEAD) dead_q    <= wr_data_i[DT_W-1:0];
      if (wr_addr_i == A_POL)  pol_q     <= cpwm_pol_t'(wr_data_i[1:0]);
    end
  end

  assign clr_wr = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[0];

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_cmp_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_shd_q[k] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(int'(A_CMP0) + k))
        cmp_shd_q[k] <= wr_data_i;
    end
  end

  cpwm_timebase #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mod_shd_i(mod_shd_q),
    .cmp_shd_i(cmp_shd_q),
    .cnt_o    (cnt),
    .cmp_act_o(cmp_act),
    .wrap_o   (wrap)
  );

  cpwm_fault u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_i),
    .clr_i  (clr_wr),
    .wrap_i (wrap),
    .halt_o (halt)
  );

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .halt_i   (halt),
      .cnt_i    (cnt),
      .cmp_i    (cmp_act[k]),
      .dead_i   (dead_q),
      .top_act_o(top_act[k]),
      .bot_act_o(bot_act[k])
    );

    assign pwm_top_o[k] = (top_act[k] && !halt) ^ pol_q.top_low;
    assign pwm_bot_o[k] = (bot_act[k] && !halt) ^ pol_q.bot_low;
  end
endmodule

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb_top;
  localparam int NP = 3;

  typedef struct {
    string     tag;
    int        mod;
    int        dt;
    logic [1:0] pol;
    int        cmp [NP];
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic        fault_i = 1'b0;
  logic [NP-1:0] pwm_top_o;
  logic [NP-1:0] pwm_bot_o;

  int nchecks = 0;
  int nerrors = 0;
  int cyc = 0;
  int cur_mod = 1;
  logic [1:0] cur_pol = 2'b00;
  bit   req = 1'b0;
  item_t exp_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  cpwm_top dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .fault_i  (fault_i),
    .pwm_top_o(pwm_top_o),
    .pwm_bot_o(pwm_bot_o)
  );

  task automatic chk(string r, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) sample();
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 12'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic int top_exp(int m, int c, int d);
    if (c == 0) return 0;
    if (c >= m) return m;
    return (c > d) ? c - d : 0;
  endfunction

  function automatic int bot_exp(int m, int c, int d);
    if (c == 0) return m;
    if (c >= m) return 0;
    return (m - c > d) ? m - c - d : 0;
  endfunction

  function automatic logic ta(int k);
    return pwm_top_o[k] ^ cur_pol[0];
  endfunction

  function automatic logic ba(int k);
    return pwm_bot_o[k] ^ cur_pol[1];
  endfunction

  task automatic push(item_t it);
    exp_q.push_back(it);
    req = 1'b1;
    wait (req == 1'b0);
  endtask

  task automatic run_cfg(string tag, int m, int d, logic [1:0] p, int c0, int c1, int c2);
    item_t it;
    int old;
    old = cur_mod;
    wr(2, int'(p));
    cur_pol = p;
    wr(1, d);
    wr(4, c0); wr(5, c1); wr(6, c2);
    wr(0, m);
    cur_mod = m;
    wait_cyc(old + 3 * m + d + 8);
    it.tag = tag; it.mod = m; it.dt = d; it.pol = p;
    it.cmp[0] = c0; it.cmp[1] = c1; it.cmp[2] = c2;
    push(it);
  endtask

  // monitor: measures a window of exactly four periods per expected item
  initial begin
    item_t it;
    forever begin
      wait (req == 1'b1);
      it = exp_q.pop_front();
      begin
        int tcnt [NP];
        int bcnt [NP];
        int ovl  [NP];
        int rise [NP];
        logic prev [NP];
        int win;
        int t;
        win = 4 * it.mod;
        sample();
        for (int k = 0; k < NP; k++) begin
          tcnt[k] = 0; bcnt[k] = 0; ovl[k] = 0; rise[k] = 0; prev[k] = ta(k);
        end
        for (int i = 0; i < win; i++) begin
          sample();
          for (int k = 0; k < NP; k++) begin
            if (ta(k)) tcnt[k]++;
            if (ba(k)) bcnt[k]++;
            if (ta(k) && ba(k)) ovl[k]++;
            if (ta(k) && !prev[k]) rise[k]++;
            prev[k] = ta(k);
          end
        end
        for (int k = 0; k < NP; k++) begin
          t = top_exp(it.mod, it.cmp[k], it.dt);
          chk({it.tag, " top active count"}, tcnt[k], 4 * t);
          chk({it.tag, " bottom active count"}, bcnt[k], 4 * bot_exp(it.mod, it.cmp[k], it.dt));
          chk("R3 top/bottom overlap", ovl[k], 0);
          chk("R1 top turn-ons per four periods", rise[k], (t > 0 && t < it.mod) ? 4 : 0);
        end
      end
      req = 1'b0;
    end
  end

  initial begin
    #(4 * 150000);
    nerrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks + 1);
    $finish;
  end

  initial begin
    int bad;
    int c0;
    int first;
    item_t it;

    // R10 reset state
    wait_cyc(3);
    chk("R10 top outputs in reset", int'(pwm_top_o), 0);
    chk("R10 bottom outputs in reset", int'(pwm_bot_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_cyc(2);

    run_cfg("R2", 20, 2, 2'b00, 5, 10, 15);
    run_cfg("R2 zero dead-time", 33, 0, 2'b00, 7, 1, 32);
    run_cfg("R5", 33, 0, 2'b00, 0, 33, 50);
    run_cfg("R5 with dead-time", 17, 4, 2'b00, 0, 200, 17);
    run_cfg("R4", 16, 6, 2'b00, 4, 6, 7);
    run_cfg("R7 both active-low", 24, 3, 2'b11, 8, 12, 20);
    run_cfg("R7 top active-low", 24, 3, 2'b01, 8, 12, 20);
    run_cfg("R1 modulus change", 9, 1, 2'b00, 3, 4, 5);

    // R6 buffered compare
    run_cfg("R2 before reload", 100, 1, 2'b00, 50, 50, 50);
    bad = 0;
    do begin
      logic p;
      p = ta(0);
      sample();
      if (p && !ta(0)) bad = 1;
    end while (bad == 0);
    wr(4, 80);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      sample();
      if (ta(0)) bad++;
    end
    chk("R6 compare change held to wrap", bad, 0);
    wait_cyc(200);
    it.tag = "R6 after reload"; it.mod = 100; it.dt = 1; it.pol = 2'b00;
    it.cmp[0] = 80; it.cmp[1] = 50; it.cmp[2] = 50;
    push(it);

    // R8 / R9 fault
    run_cfg("R2 before fault", 40, 2, 2'b10, 10, 10, 10);
    bad = 0;
    do begin
      logic p;
      p = ta(0);
      sample();
      if (p && !ta(0)) bad = 1;
    end while (bad == 0);
    c0 = cyc;
    @(negedge clk_i);
    fault_i = 1'b1;
    #1;
    chk("R8 top pins at fault", int'(pwm_top_o), 0);
    chk("R8 bottom pins at fault", int'(pwm_bot_o), 7);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      sample();
      if (pwm_top_o != 3'b000 || pwm_bot_o != 3'b111) bad++;
    end
    chk("R8 outputs inactive during fault", bad, 0);
    @(negedge clk_i);
    fault_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      sample();
      if (pwm_top_o != 3'b000 || pwm_bot_o != 3'b111) bad++;
    end
    chk("R9 latched without clear", bad, 0);
    @(negedge clk_i);
    fault_i = 1'b1;
    wr(3, 1);
    @(negedge clk_i);
    fault_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      sample();
      if (pwm_top_o != 3'b000 || pwm_bot_o != 3'b111) bad++;
    end
    chk("R9 clear during fault discarded", bad, 0);
    while (((cyc - c0) % 40) != 0) sample();
    wr(3, 1);
    first = 0;
    for (int i = 0; i < 120 && first == 0; i++) begin
      sample();
      if (ta(0) || ta(1) || ta(2) || ba(0) || ba(1) || ba(2))
        first = (ta(0) && !ba(0) && !ba(1) && !ba(2)) ? 1 : 2;
    end
    chk("R9 resume at wrap with top first", first, 1);
    wait_cyc(45);
    it.tag = "R8 after resume"; it.mod = 40; it.dt = 2; it.pol = 2'b10;
    it.cmp[0] = 10; it.cmp[1] = 10; it.cmp[2] = 10;
    push(it);

    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  end
endmodule